// File: doc/BRIEF.md
# Single-Error-Correcting Block Codec

This block holds two independent combinational paths for a single-error-correcting block code. The encode path takes a data word and returns a codeword. Check bits sit at the power-of-two positions, and data bits fill the remaining positions in ascending order. The decode path takes a received word that may be corrupted and forms a syndrome from the check groups. The syndrome value is the position of the faulty bit, so the path inverts that one bit and then extracts the data. It also reports the syndrome and an error flag.

The width is set by one parameter, `PAR_W`, which is the number of check bits. The codeword length is 2^PAR_W − 1 and the data width is that length minus `PAR_W`. The default `PAR_W = 3` gives 4 data bits in a 7-bit codeword. Positions are numbered from 1, and position p is carried on codeword bit p−1. The block has no clock or state: each output depends only on the input of its own path.

Top module: `ham_sec_codec`

## Requirements
- R1: Data bit k appears at the k-th position that is not a power of two. With the defaults, d0, d1, d2 and d3 are on positions 3, 5, 6 and 7, which are codeword bits 2, 4, 5 and 6.
- R2: The check bit at position 1 (codeword bit 0) gives even parity over positions 1, 3, 5 and 7.
- R3: The check bit at position 2 (codeword bit 1) gives even parity over positions 2, 3, 6 and 7.
- R4: The check bit at position 4 (codeword bit 3) gives even parity over positions 4, 5, 6 and 7.
- R5: Syndrome bit j is 1 when the parity group of position 2^j fails, so bit 0 belongs to position 1 and bit 2 (the MSB) to position 4. After a single flipped bit, the syndrome equals that bit's position; for example, a flip at position 5 gives 3'b101.
- R6: A zero syndrome leaves the received word untouched: the data bits are read straight from their positions and the error flag is 0.
- R7: A nonzero syndrome inverts exactly the bit at the named position before the data is read out, and the error flag is 1. Any single-bit error in a codeword therefore returns the original data.
- R8: Any word produced by the encode path gives a zero syndrome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data_i | input | 2^PAR_W−1−PAR_W | Data word to encode |
| enc_code_o | output | 2^PAR_W−1 | Codeword, position p on bit p−1 |
| dec_code_i | input | 2^PAR_W−1 | Received word, possibly corrupted |
| dec_data_o | output | 2^PAR_W−1−PAR_W | Data read from the corrected word |
| dec_syn_o | output | PAR_W | Syndrome, equal to the faulty position or 0 |
| dec_err_o | output | 1 | High when the syndrome is nonzero |

## Verification
The bench builds the block only with the default `PAR_W = 3`, which gives 16 data values and 7 positions. At that size the bench can encode every data value, decode every clean codeword, and inject every single-bit error into every codeword. Each corrupted word is checked for recovered data, syndrome and flag. Randomly chosen 7-bit words then cover double and triple errors, where the bench expects the same one-bit correction named by the syndrome.

// File: rtl/ham_sec_pkg.sv
`timescale 1ns/1ps
package ham_sec_pkg;

  function automatic bit is_pow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // position (1-based) of data bit k
  function automatic int data_pos(int k);
    int cnt;
    cnt = 0;
    for (int p = 1; p < 1024; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == k) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/ham_sec_enc.sv
`timescale 1ns/1ps
module ham_sec_enc #(
  parameter int PAR_W = 3,
  localparam int CW_W = (1 << PAR_W) - 1,
  localparam int DAT_W = CW_W - PAR_W
) (
  input  logic [DAT_W-1:0] data_i,
  output logic [CW_W-1:0]  code_o
);
  for (genvar k = 0; k < DAT_W; k++) begin : g_dat
    localparam int DP = ham_sec_pkg::data_pos(k);
    assign code_o[DP-1] = data_i[k];
  end

  for (genvar j = 0; j < PAR_W; j++) begin : g_par
    logic [DAT_W-1:0] sel;
    for (genvar k = 0; k < DAT_W; k++) begin : g_sel
      localparam int DP = ham_sec_pkg::data_pos(k);
      if (((DP >> j) & 1) != 0) begin : g_on
        assign sel[k] = data_i[k];
      end else begin : g_off
        assign sel[k] = 1'b0;
      end
    end
    assign code_o[(1 << j) - 1] = ^sel;
  end
endmodule

// File: rtl/ham_sec_syn.sv
`timescale 1ns/1ps
module ham_sec_syn #(
  parameter int PAR_W = 3,
  localparam int CW_W = (1 << PAR_W) - 1
) (
  input  logic [CW_W-1:0]  word_i,
  output logic [PAR_W-1:0] syn_o
);
  for (genvar j = 0; j < PAR_W; j++) begin : g_chk
    logic [CW_W-1:0] grp;
    for (genvar q = 1; q <= CW_W; q++) begin : g_pos
      if (((q >> j) & 1) != 0) begin : g_on
        assign grp[q-1] = word_i[q-1];
      end else begin : g_off
        assign grp[q-1] = 1'b0;
      end
    end
    assign syn_o[j] = ^grp;
  end
endmodule

// File: rtl/ham_sec_fix.sv
`timescale 1ns/1ps
module ham_sec_fix #(
  parameter int PAR_W = 3,
  localparam int CW_W = (1 << PAR_W) - 1,
  localparam int DAT_W = CW_W - PAR_W
) (
  input  logic [CW_W-1:0]  word_i,
  input  logic [PAR_W-1:0] syn_i,
  output logic [CW_W-1:0]  fixed_o,
  output logic [DAT_W-1:0] data_o,
  output logic             err_o
);
  logic [CW_W-1:0] flip;

  for (genvar q = 1; q <= CW_W; q++) begin : g_flip
    assign flip[q-1] = (syn_i == PAR_W'(q));
  end

  assign fixed_o = word_i ^ flip;
  assign err_o   = |syn_i;

  for (genvar k = 0; k < DAT_W; k++) begin : g_ext
    localparam int DP = ham_sec_pkg::data_pos(k);
    assign data_o[k] = fixed_o[DP-1];
  end
endmodule

// File: rtl/ham_sec_codec.sv
`timescale 1ns/1ps
module ham_sec_codec #(
  parameter int PAR_W = 3,
  localparam int CW_W = (1 << PAR_W) - 1,
  localparam int DAT_W = CW_W - PAR_W
) (
  input  logic [DAT_W-1:0] enc_data_i,
  output logic [CW_W-1:0]  enc_code_o,
  input  logic [CW_W-1:0]  dec_code_i,
  output logic [DAT_W-1:0] dec_data_o,
  output logic [PAR_W-1:0] dec_syn_o,
  output logic             dec_err_o
);
  logic [CW_W-1:0] fixed_w;

  ham_sec_enc #(.PAR_W(PAR_W)) u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code_o)
  );

  ham_sec_syn #(.PAR_W(PAR_W)) u_syn (
    .word_i (dec_code_i),
    .syn_o  (dec_syn_o)
  );

  ham_sec_fix #(.PAR_W(PAR_W)) u_fix (
    .word_i  (dec_code_i),
    .syn_i   (dec_syn_o),
    .fixed_o (fixed_w),
    .data_o  (dec_data_o),
    .err_o   (dec_err_o)
  );
endmodule

// File: rtl/ham_sec_codec_chk.sv
`timescale 1ns/1ps
module ham_sec_codec_chk #(
  parameter int PAR_W = 3,
  localparam int CW_W = (1 << PAR_W) - 1,
  localparam int DAT_W = CW_W - PAR_W
) (
  input logic [DAT_W-1:0] enc_data_i,
  input logic [CW_W-1:0]  enc_code_o,
  input logic [CW_W-1:0]  dec_code_i,
  input logic [DAT_W-1:0] dec_data_o,
  input logic [PAR_W-1:0] dec_syn_o,
  input logic             dec_err_o,
  input logic [CW_W-1:0]  fixed_w
);
  logic [PAR_W-1:0] enc_syn;
  logic [DAT_W-1:0] enc_dat, raw_dat;
  logic [CW_W-1:0]  diff;

  ham_sec_syn #(.PAR_W(PAR_W)) u_resyn (
    .word_i (enc_code_o),
    .syn_o  (enc_syn)
  );

  for (genvar k = 0; k < DAT_W; k++) begin : g_pick
    localparam int DP = ham_sec_pkg::data_pos(k);
    assign enc_dat[k] = enc_code_o[DP-1];
    assign raw_dat[k] = dec_code_i[DP-1];
  end

  assign diff = dec_code_i ^ fixed_w;

  always_comb begin
    AST_ENC_DATA_FIELDS: assert (enc_dat == enc_data_i) else $error("enc data fields"); // R1
    AST_ENC_GRP1_EVEN: assert (enc_syn[0] == 1'b0) else $error("group 1 odd"); // R2
    AST_ENC_GRP2_EVEN: assert (enc_syn[1] == 1'b0) else $error("group 2 odd"); // R3
    AST_ENC_GRP4_EVEN: assert (enc_syn[2] == 1'b0) else $error("group 4 odd"); // R4
    AST_ENC_ROUNDTRIP: assert (enc_syn == '0) else $error("codeword syndrome"); // R8
    AST_FIX_AT_SYN_POS: assert (!dec_err_o || diff[dec_syn_o - PAR_W'(1)]) else $error("wrong bit fixed"); // R5
    AST_CLEAN_PASSTHRU: assert (dec_err_o || (dec_data_o == raw_dat && diff == '0)) else $error("clean word altered"); // R6
    AST_ONE_BIT_FLIP: assert ($countones(diff) == (dec_err_o ? 1 : 0)) else $error("flip count"); // R7
  end
endmodule

bind ham_sec_codec ham_sec_codec_chk #(.PAR_W(PAR_W)) u_chk (
  .enc_data_i (enc_data_i),
  .enc_code_o (enc_code_o),
  .dec_code_i (dec_code_i),
  .dec_data_o (dec_data_o),
  .dec_syn_o  (dec_syn_o),
  .dec_err_o  (dec_err_o),
  .fixed_w    (fixed_w)
);

// File: tb/sim_ham_sec_codec.sv
`timescale 1ns/1ps
module sim_ham_sec_codec;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] enc_data_i = '0;
  logic [6:0] enc_code_o;
  logic [6:0] dec_code_i = '0;
  logic [3:0] dec_data_o;
  logic [2:0] dec_syn_o;
  logic       dec_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  ham_sec_codec u0 (
    .enc_data_i (enc_data_i),
    .enc_code_o (enc_code_o),
    .dec_code_i (dec_code_i),
    .dec_data_o (dec_data_o),
    .dec_syn_o  (dec_syn_o),
    .dec_err_o  (dec_err_o)
  );

  function automatic logic [6:0] ref_enc(logic [3:0] d);
    logic p1, p2, p4;
    p1 = d[0] ^ d[1] ^ d[3];
    p2 = d[0] ^ d[2] ^ d[3];
    p4 = d[1] ^ d[2] ^ d[3];
    return {d[3], d[2], d[1], p4, d[0], p2, p1};
  endfunction

  function automatic logic [2:0] ref_syn(logic [6:0] w);
    return {w[3] ^ w[4] ^ w[5] ^ w[6],
            w[1] ^ w[2] ^ w[5] ^ w[6],
            w[0] ^ w[2] ^ w[4] ^ w[6]};
  endfunction

  function automatic logic [3:0] ref_dat(logic [6:0] w);
    logic [2:0] s;
    s = ref_syn(w);
    if (s != 3'd0) w[s - 3'd1] = ~w[s - 3'd1];
    return {w[6], w[5], w[4], w[2]};
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] d, logic [6:0] w);
    @(negedge clk_i);
    enc_data_i = d;
    dec_code_i = w;
    #1;
  endtask

  task automatic check_dec(string req, logic [6:0] w, logic [3:0] d_exp, logic [2:0] s_exp);
    check({req, " data"}, int'(dec_data_o), int'(d_exp));
    check({req, " syndrome"}, int'(dec_syn_o), int'(s_exp));
    check({req, " flag"}, int'(dec_err_o), int'(s_exp != 3'd0));
  endtask

  initial begin
    logic [6:0] cw, w;
    logic [3:0] d;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;

    // idle state: all-zero inputs
    apply(4'h0, 7'h00);
    check("R1 zero codeword", int'(enc_code_o), 0);
    check_dec("R6 zero word", 7'h00, 4'h0, 3'd0);

    for (int v = 0; v < 16; v++) begin
      d = 4'(v);
      cw = ref_enc(d);
      apply(d, cw);
      check("R1 data positions", int'({enc_code_o[6], enc_code_o[5], enc_code_o[4], enc_code_o[2]}), int'(d));
      check("R2 check bit pos1", int'(enc_code_o[0]), int'(cw[0]));
      check("R3 check bit pos2", int'(enc_code_o[1]), int'(cw[1]));
      check("R4 check bit pos4", int'(enc_code_o[3]), int'(cw[3]));
      check_dec("R6 R8 clean codeword", cw, d, 3'd0);
      for (int p = 1; p <= 7; p++) begin
        w = cw ^ (7'd1 << (p - 1));
        apply(d, w);
        check_dec("R5 R7 single error", w, d, 3'(p));
      end
    end

    // syndrome example: position 5 flipped
    cw = ref_enc(4'hA);
    apply(4'hA, cw ^ 7'b0010000);
    check("R5 pos5 syndrome", int'(dec_syn_o), 5);
    check("R7 pos5 data", int'(dec_data_o), 4'hA);

    // all-ones corner
    apply(4'hF, 7'h7F);
    check("R1 all ones codeword", int'(enc_code_o), 7'h7F);
    check_dec("R6 all ones word", 7'h7F, 4'hF, 3'd0);

    // random words, any error weight
    for (int i = 0; i < 300; i++) begin
      d = 4'($urandom);
      w = 7'($urandom);
      apply(d, w);
      check("R1 R2 R3 R4 random encode", int'(enc_code_o), int'(ref_enc(d)));
      check_dec("R5 R6 R7 random word", w, ref_dat(w), ref_syn(w));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule